// File: doc/BRIEF.md
# Zero-Register Dual-Read Register File

This block holds the working registers of a small processor datapath. It keeps thirty-two 32-bit words, and any two of them can be read at once through two independent read ports. Each read port turns a 5-bit address into a data word through combinational logic, with no clock involved. A single write port stores one word on the rising clock edge. The write happens only when its enable is high, and it goes to the one register that a decoder picks out from the write address.

The highest address, 31, is not storage. Only entries 0 to 30 are flops. Both read selectors return a hard zero for address 31, and a write to that address is dropped. Software can therefore use entry 31 as an always-zero source and as a place to discard results.

A write does not bypass to the read ports. A read of a register in the same cycle that the register is being written returns the value it held before the write. The new value can be read from the first cycle after the edge. A synchronous, active-high reset clears entries 0 to 30 and takes priority over a write in the same cycle.

Top module: `zreg_file`

## Requirements
- R1: The file holds 32 entries of 32 bits. Read port A returns the entry at `rd_addr_a`, and read port B returns the entry at `rd_addr_b`. Both ports are combinational and independent, so they may address the same or different entries in the same cycle.
- R2: For address 31, both read ports always return 32'h0000_0000.
- R3: When `wr_en` is 1 at a rising edge and `wr_addr` is in 0..30, the entry at `wr_addr` takes `wr_data`, and reads return that value from the next cycle on.
- R4: When `wr_en` is 0 at a rising edge, no entry changes.
- R5: A write with `wr_addr` = 31 changes no entry, and address 31 still reads zero afterwards.
- R6: When `rst` is 1 at a rising edge, entries 0..30 become zero. This happens even if `wr_en` is 1 in the same cycle.
- R7: A read of the entry being written in the same cycle returns the old value, not `wr_data`.
- R8: A write changes only the addressed entry. Every other entry keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by every entry |
| rst | input | 1 | Synchronous active-high clear of entries 0..30 |
| rd_addr_a | input | 5 | Read port A address |
| rd_data_a | output | 32 | Read port A data |
| rd_addr_b | input | 5 | Read port B address |
| rd_data_b | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data |

## Verification
The bench writes distinct, arithmetically generated words to every address, including 31. After each phase it reads back all 32 entries through both ports, so a decoder that enables a neighbouring entry or more than one entry shows up as a corrupted word somewhere in the sweep. A selector that reads real storage at address 31 would return written data instead of zero. A forwarding path would show the new word during the write cycle instead of the old one. A reset that loses to a simultaneous write would leave that word in place. Cycles with the enable low still carry live address and data, so a decoder that ignores the enable changes an entry.

// File: rtl/zreg_file_pkg.sv
package zreg_file_pkg;

    localparam int RF_DATA_W   = 32;
    localparam int RF_ADDR_W   = 5;
    localparam int RF_ENTRIES  = 1 << RF_ADDR_W;
    localparam int RF_STORE    = RF_ENTRIES - 1;
    localparam int RF_ZERO_IDX = RF_ENTRIES - 1;
    localparam int RF_RD_PORTS = 2;

    typedef logic [RF_DATA_W-1:0] word_t;
    typedef logic [RF_ADDR_W-1:0] addr_t;
    typedef logic [RF_STORE-1:0]  sel_t;
    typedef logic [RF_STORE-1:0][RF_DATA_W-1:0] bank_t;

    typedef struct packed {
        logic  en;
        addr_t addr;
        word_t data;
    } wr_req_t;

    function automatic logic is_zero_addr(addr_t a);
        return a == addr_t'(RF_ZERO_IDX);
    endfunction

endpackage

// File: rtl/zreg_wr_decode.sv
module zreg_wr_decode
    import zreg_file_pkg::*;
(
    input  wr_req_t req,
    output sel_t    sel
);
    for (genvar i = 0; i < RF_STORE; i++) begin : g_dec
        assign sel[i] = req.en && (req.addr == addr_t'(i));
    end
endmodule

// File: rtl/zreg_store.sv
module zreg_store
    import zreg_file_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  sel_t  sel,
    input  word_t data,
    output bank_t bank
);
    for (genvar i = 0; i < RF_STORE; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                bank[i] <= '0;
            end else if (sel[i]) begin
                bank[i] <= data;
            end
        end
    end
endmodule

// File: rtl/zreg_rd_sel.sv
module zreg_rd_sel
    import zreg_file_pkg::*;
(
    input  bank_t bank,
    input  addr_t addr,
    output word_t data
);
    always_comb begin
        data = '0;
        if (!is_zero_addr(addr)) begin
            for (int i = 0; i < RF_STORE; i++) begin
                if (addr == addr_t'(i)) begin
                    data = bank[i];
                end
            end
        end
    end
endmodule

// File: rtl/zreg_file.sv
module zreg_file
    import zreg_file_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  rd_addr_a,
    output logic [31:0] rd_data_a,
    input  logic [4:0]  rd_addr_b,
    output logic [31:0] rd_data_b,
    input  logic        wr_en,
    input  logic [4:0]  wr_addr,
    input  logic [31:0] wr_data
);
    wr_req_t wreq;
    sel_t    wr_sel;
    bank_t   bank;
    addr_t   rd_addr [RF_RD_PORTS];
    word_t   rd_data [RF_RD_PORTS];

    assign wreq = '{en: wr_en, addr: wr_addr, data: wr_data};

    zreg_wr_decode u_dec (
        .req (wreq),
        .sel (wr_sel)
    );

    zreg_store u_store (
        .clk  (clk),
        .rst  (rst),
        .sel  (wr_sel),
        .data (wreq.data),
        .bank (bank)
    );

    assign rd_addr[0] = rd_addr_a;
    assign rd_addr[1] = rd_addr_b;

    for (genvar p = 0; p < RF_RD_PORTS; p++) begin : g_rd
        zreg_rd_sel u_sel (
            .bank (bank),
            .addr (rd_addr[p]),
            .data (rd_data[p])
        );
    end

    assign rd_data_a = rd_data[0];
    assign rd_data_b = rd_data[1];
endmodule

// File: rtl/zreg_file_checker.sv
module zreg_file_checker
    import zreg_file_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [4:0]  rd_addr_a,
    input logic [31:0] rd_data_a,
    input logic [4:0]  rd_addr_b,
    input logic [31:0] rd_data_b,
    input logic        wr_en,
    input logic [4:0]  wr_addr,
    input logic [31:0] wr_data,
    input sel_t        wr_sel
);
    // R8: at most one entry enabled per cycle
    p_single_enable_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_sel));

    // R4: no enable without wr_en
    p_no_enable_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> (wr_sel == '0));

    // R2 / R5: address 31 reads zero on both ports
    p_zero_a_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_a == 5'd31) |-> (rd_data_a == 32'h0));
    p_zero_b_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_b == 5'd31) |-> (rd_data_b == 32'h0));

    // R3: written word readable next cycle
    p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != 5'd31) |=>
            ((rd_addr_a != $past(wr_addr)) || (rd_data_a == $past(wr_data))));

    // R4: an idle edge keeps the addressed word
    p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en) && rd_addr_b == $past(rd_addr_b))
            |-> (rd_data_b == $past(rd_data_b)));

    // R6: cleared after reset
    p_reset_clear_r6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_data_a == 32'h0 && rd_data_b == 32'h0));
endmodule

bind zreg_file zreg_file_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_addr_a (rd_addr_a),
    .rd_data_a (rd_data_a),
    .rd_addr_b (rd_addr_b),
    .rd_data_b (rd_data_b),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_sel    (wr_sel)
);

// File: tb/tb_zreg_file.sv
module tb_zreg_file;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  rd_addr_a = '0;
    logic [31:0] rd_data_a;
    logic [4:0]  rd_addr_b = '0;
    logic [31:0] rd_data_b;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;

    logic [31:0] model [32];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    zreg_file dut (
        .clk(clk), .rst(rst),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    function automatic logic [31:0] pat(int i, int seed);
        return (32'h9E37_79B9 * (i + 1)) ^ (32'h0101_0101 * seed) ^ {i[7:0], 24'h5A5A5A};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock with given write inputs; inputs driven at negedge
    task automatic cycle(logic en, logic [4:0] a, logic [31:0] d, logic r);
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d; rst = r;
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < 31; i++) model[i] = '0;
        end else if (en && a != 5'd31) begin
            model[a] = d;
        end
        @(negedge clk);
        wr_en = 1'b0; rst = 1'b0;
    endtask

    // read every entry on both ports, port B in reverse order
    task automatic sweep(string req);
        for (int i = 0; i < 32; i++) begin
            rd_addr_a = 5'(i);
            rd_addr_b = 5'(31 - i);
            #1;
            check(req, rd_data_a, (i == 31) ? 32'h0 : model[i]);
            check(req, rd_data_b, (i == 0) ? 32'h0 : model[31 - i]);
        end
    endtask

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        sweep("R6 reset state");

        for (int i = 0; i < 32; i++) cycle(1'b1, 5'(i), pat(i, 1), 1'b0);
        sweep("R3/R8 write all, R5 addr31 zero");

        for (int i = 0; i < 32; i++) cycle(1'b0, 5'(i), ~pat(i, 7), 1'b0);
        sweep("R4 enable low no change");

        // single writes: only addressed entry changes
        for (int i = 0; i < 31; i += 5) begin
            cycle(1'b1, 5'(i), pat(i, 3), 1'b0);
            sweep("R8 only addressed entry");
        end

        cycle(1'b1, 5'd31, 32'hFFFF_FFFF, 1'b0);
        sweep("R5 write to 31 dropped");

        // R1 same address on both ports
        for (int i = 0; i < 31; i++) begin
            rd_addr_a = 5'(i); rd_addr_b = 5'(i); #1;
            check("R1 both ports same entry", rd_data_a, model[i]);
            check("R1 both ports same entry", rd_data_b, model[i]);
        end

        // R7 same-cycle read returns old value
        for (int i = 2; i < 31; i += 7) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 5'(i); wr_data = pat(i, 9);
            rd_addr_a = 5'(i); rd_addr_b = 5'(i); #1;
            check("R7 old value during write", rd_data_a, model[i]);
            check("R7 old value during write", rd_data_b, model[i]);
            @(posedge clk);
            model[i] = pat(i, 9);
            @(negedge clk);
            wr_en = 1'b0; #1;
            check("R3 new value after edge", rd_data_a, model[i]);
        end

        // R6 reset wins over write
        cycle(1'b1, 5'd4, 32'hDEAD_BEEF, 1'b1);
        sweep("R6 reset beats write");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule